// File: doc/BRIEF.md
# Fractal Engine Pool Dispatcher and Collector

This block feeds a pool of identical escape-time iteration engines and gathers their answers into a frame buffer. It walks the raster one pixel at a time, left to right and then top to bottom. It turns each position into a complex-plane coordinate in signed Q8.24 fixed point and gives that coordinate to an engine that is free. Engines may finish in any order. The block remembers which linear pixel address each engine is working on, so every result goes to the address of its own pixel.

Results leave through the write side of a dual-port frame memory; a display reader uses the other side. Once every pixel of the frame has been written, the block raises a one-cycle frame-complete pulse and starts the next frame at pixel 0. The pool size, the raster size, the result width and the plane mapping are all parameters. The engines run on the same clock as this block.

A handshake per engine connects the two. The engine shows `eng_idle` while it can take work. The block answers with a one-cycle `eng_start`. The engine raises `eng_done` with its result held steady. The block answers with a one-cycle `eng_ack`, and the engine then returns to idle.

Top module: `pool_dispatcher`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `eng_start`, `eng_ack`, `fb_we` and `frame_done` are all 0.
- R2: `eng_start` has at most one bit set per cycle. A bit is set only for an engine that showed `eng_idle` at the sampling edge and that does not already hold a pixel. When several engines qualify, the lowest-numbered one is chosen. Every free engine is used while pixels of the current frame remain.
- R3: The k-th pixel dispatched in a frame has column c = k mod COLS and row r = k / COLS. It is issued with `eng_cx` = X_MIN + c*STEP and `eng_cy` = Y_MAX - r*STEP, two's-complement Q8.24 (defaults -2.0, 1.2 and 3.0/640 rounded down to 78643 LSB).
- R4: Each write-back puts `fb_addr` = r*COLS + c of the pixel that the acknowledged engine was given. `fb_data` is that engine's `eng_result` slice, bits [i*RES_W +: RES_W].
- R5: Each address from 0 to COLS*ROWS-1 is written exactly once per frame.
- R6: At most one engine is collected per cycle. This is the lowest-numbered engine that shows `eng_done` while it holds a pixel. Its `eng_ack` bit pulses in the same cycle as `fb_we`.
- R7: `frame_done` pulses for one cycle, together with the final write of a frame. The next dispatch carries pixel 0 (`eng_cx` = X_MIN, `eng_cy` = Y_MAX).
- R8: With a pool of 12 engines, all 12 can hold pixels at the same time. No engine is given a second pixel before its first result is collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the engines |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_idle | input | NUM_ENG | Engine i can accept a coordinate |
| eng_done | input | NUM_ENG | Engine i holds a finished result |
| eng_result | input | NUM_ENG*RES_W | Packed results, engine i at [i*RES_W +: RES_W] |
| eng_start | output | NUM_ENG | One-cycle start pulse to one engine |
| eng_cx | output | 32 | Real part of the issued coordinate, Q8.24 |
| eng_cy | output | 32 | Imaginary part of the issued coordinate, Q8.24 |
| eng_ack | output | NUM_ENG | One-cycle pulse telling engine i its result was taken |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_addr | output | AW | Frame-buffer write address |
| fb_data | output | RES_W | Frame-buffer write data |
| frame_done | output | 1 | One-cycle pulse when the last pixel of a frame is written |

## Verification
Dispatch of a new pixel and write-back of a finished one happen in the same cycle whenever one engine is free while another is done. Short random engine latencies make this frequent. The bench counts such cycles and requires at least one. In each of those cycles it checks both sides against its own model: which engines hold pixels, which pixel went to which engine, and which engine should win on each side. This confirms that the pixel just handed out never disturbs the address written back for a different engine, and that an engine freed by an acknowledge is not started again in that same cycle.

// File: rtl/pool_dispatcher.sv
module pool_dispatcher #(
  parameter int NUM_ENG = 12,
  parameter int COLS    = 640,
  parameter int ROWS    = 480,
  parameter int RES_W   = 8,
  parameter logic signed [31:0] X_MIN = -32'sd33554432,
  parameter logic signed [31:0] Y_MAX = 32'sd20132659,
  parameter logic signed [31:0] STEP  = 32'sd78643,
  localparam int TOTAL = COLS * ROWS,
  localparam int AW    = $clog2(TOTAL),
  localparam int CW    = $clog2(COLS),
  localparam int IW    = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ENG-1:0]       eng_idle,
  input  logic [NUM_ENG-1:0]       eng_done,
  input  logic [NUM_ENG*RES_W-1:0] eng_result,
  output logic [NUM_ENG-1:0]       eng_start,
  output logic signed [31:0]       eng_cx,
  output logic signed [31:0]       eng_cy,
  output logic [NUM_ENG-1:0]       eng_ack,
  output logic                     fb_we,
  output logic [AW-1:0]            fb_addr,
  output logic [RES_W-1:0]         fb_data,
  output logic                     frame_done
);

  logic [NUM_ENG-1:0] held;
  logic [AW-1:0]      tag [NUM_ENG];
  logic [AW-1:0]      pix, wr_cnt;
  logic [CW-1:0]      col;
  logic signed [31:0] cx, cy;
  logic               all_sent;

  wire [NUM_ENG-1:0] free  = eng_idle & ~held;
  wire [NUM_ENG-1:0] ready = eng_done & held;

  logic [IW-1:0] d_sel, c_sel;
  logic          d_hit, c_hit;

  always_comb begin
    d_sel = '0; d_hit = 1'b0;
    c_sel = '0; c_hit = 1'b0;
    for (int i = NUM_ENG - 1; i >= 0; i--) begin
      if (free[i])  begin d_hit = 1'b1; d_sel = IW'(i); end
      if (ready[i]) begin c_hit = 1'b1; c_sel = IW'(i); end
    end
  end

  wire dispatch = d_hit & ~all_sent;
  wire collect  = c_hit;
  wire [NUM_ENG-1:0] set_m = dispatch ? (NUM_ENG'(1) << d_sel) : '0;
  wire [NUM_ENG-1:0] clr_m = collect  ? (NUM_ENG'(1) << c_sel) : '0;

  always_ff @(posedge clk) begin
    if (dispatch) tag[d_sel] <= pix;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= '0;
      pix        <= '0;
      col        <= '0;
      cx         <= X_MIN;
      cy         <= Y_MAX;
      all_sent   <= 1'b0;
      wr_cnt     <= '0;
      eng_start  <= '0;
      eng_ack    <= '0;
      eng_cx     <= '0;
      eng_cy     <= '0;
      fb_we      <= 1'b0;
      fb_addr    <= '0;
      fb_data    <= '0;
      frame_done <= 1'b0;
    end else begin
      eng_start  <= set_m;
      eng_ack    <= clr_m;
      fb_we      <= collect;
      frame_done <= 1'b0;
      held       <= (held & ~clr_m) | set_m;
      if (dispatch) begin
        eng_cx <= cx;
        eng_cy <= cy;
        if (pix == AW'(TOTAL - 1)) begin
          pix      <= '0;
          col      <= '0;
          cx       <= X_MIN;
          cy       <= Y_MAX;
          all_sent <= 1'b1;
        end else begin
          pix <= pix + 1'b1;
          if (col == CW'(COLS - 1)) begin
            col <= '0;
            cx  <= X_MIN;
            cy  <= cy - STEP;
          end else begin
            col <= col + 1'b1;
            cx  <= cx + STEP;
          end
        end
      end
      if (collect) begin
        fb_addr <= tag[c_sel];
        fb_data <= eng_result[c_sel*RES_W +: RES_W];
        if (wr_cnt == AW'(TOTAL - 1)) begin
          wr_cnt     <= '0;
          frame_done <= 1'b1;
          all_sent   <= 1'b0;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
    end
  end

  assert_start_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |-> ((eng_start & ~$past(eng_idle)) == '0));
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_ack));
  assert_ack_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_ack) |-> ((eng_ack & ~$past(eng_done)) == '0));
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (int'(fb_addr) < TOTAL));
  assert_frame_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> fb_we);
  assert_frame_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: tb/pool_dispatcher_test.sv
module pool_dispatcher_test;
  localparam int NE = 12, COLS = 16, ROWS = 12, RW = 8;
  localparam int TOTAL = COLS * ROWS;
  localparam int AW = $clog2(TOTAL);
  localparam int XM = -33554432, YM = 20132659, ST = 78643;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NE-1:0]    eng_idle = '1, eng_done = '0;
  logic [NE*RW-1:0] eng_result = '0;
  logic [NE-1:0]    eng_start, eng_ack;
  logic signed [31:0] eng_cx, eng_cy;
  logic          fb_we, frame_done;
  logic [AW-1:0] fb_addr;
  logic [RW-1:0] fb_data;

  pool_dispatcher #(.NUM_ENG(NE), .COLS(COLS), .ROWS(ROWS), .RES_W(RW),
    .X_MIN(XM), .Y_MAX(YM), .STEP(ST)) uut (
    .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle), .eng_done(eng_done),
    .eng_result(eng_result), .eng_start(eng_start), .eng_cx(eng_cx),
    .eng_cy(eng_cy), .eng_ack(eng_ack), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_data(fb_data), .frame_done(frame_done));

  int checks = 0, errors = 0;
  int lat_max = 4, frames = 0, overlap = 0, saturated = 0;
  int disp_cnt = 0, wr_cnt = 0;
  int cnt [NE];
  int pix_of [NE];
  int cap_x [NE], cap_y [NE];
  int hits [TOTAL];
  logic [NE-1:0] heldm = '0;
  bit mon_on = 0;

  function automatic logic [RW-1:0] mix(int a, int b);
    return RW'((a + 3 * b) >>> 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NE-1:0] lowest(input logic [NE-1:0] m);
    for (int i = 0; i < NE; i++) if (m[i]) return NE'(1) << i;
    return '0;
  endfunction

  task automatic step();
    logic [NE-1:0] exp_s, exp_a;
    int a, c, r;
    exp_s = (disp_cnt < TOTAL) ? lowest(eng_idle & ~heldm) : '0;
    exp_a = lowest(eng_done & heldm);
    chk(eng_start == exp_s, "R2 start", eng_start, exp_s);
    chk(eng_ack == exp_a, "R6 ack", eng_ack, exp_a);
    chk(fb_we == (exp_a != 0), "R6 we", fb_we, exp_a != 0);
    if (eng_start != 0 && fb_we) overlap++;
    for (int i = 0; i < NE; i++) if (eng_start[i]) begin
      c = disp_cnt % COLS; r = disp_cnt / COLS;
      chk(eng_cx == XM + c * ST, "R3 cx", eng_cx, XM + c * ST);
      chk(eng_cy == YM - r * ST, "R3 cy", eng_cy, YM - r * ST);
      pix_of[i] = disp_cnt;
      disp_cnt++;
    end
    for (int i = 0; i < NE; i++) if (eng_ack[i] && fb_we) begin
      a = pix_of[i];
      chk(int'(fb_addr) == a, "R4 addr", fb_addr, a);
      chk(fb_data == mix(XM + (a % COLS) * ST, YM - (a / COLS) * ST), "R4 data",
          fb_data, mix(XM + (a % COLS) * ST, YM - (a / COLS) * ST));
      hits[fb_addr]++;
      chk(hits[fb_addr] == 1, "R5 once", hits[fb_addr], 1);
      wr_cnt++;
    end
    chk(frame_done == (fb_we && wr_cnt == TOTAL), "R7 frame_done", frame_done,
        fb_we && wr_cnt == TOTAL);
    heldm = (heldm & ~eng_ack) | eng_start;
    if (heldm == '1) saturated++;
    if (frame_done) begin
      for (int k = 0; k < TOTAL; k++)
        if (hits[k] != 1) chk(0, "R5 coverage", hits[k], 1);
      checks++;
      foreach (hits[k]) hits[k] = 0;
      disp_cnt = 0; wr_cnt = 0; frames++;
    end
    for (int i = 0; i < NE; i++) begin
      if (eng_idle[i]) begin
        if (eng_start[i]) begin
          eng_idle[i] = 1'b0;
          cnt[i] = $urandom_range(1, lat_max);
          cap_x[i] = eng_cx; cap_y[i] = eng_cy;
        end
      end else if (!eng_done[i]) begin
        cnt[i]--;
        if (cnt[i] == 0) begin
          eng_done[i] = 1'b1;
          eng_result[i*RW +: RW] = mix(cap_x[i], cap_y[i]);
        end
      end else if (eng_ack[i]) begin
        eng_done[i] = 1'b0;
        eng_idle[i] = 1'b1;
      end
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (mon_on) step();
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(eng_start == 0 && eng_ack == 0, "R1 handshakes", {eng_start, eng_ack}, 0);
    chk(!fb_we && !frame_done, "R1 write", {fb_we, frame_done}, 0);
    @(posedge clk); rst_n = 1'b1; mon_on = 1;
  endtask

  task automatic t_frame(input int lat, input string tag);
    int f0 = frames;
    lat_max = lat;
    for (int n = 0; n < 20000 && frames == f0; n++) @(posedge clk);
    chk(frames == f0 + 1, "R7 frame completes", frames - f0, 1);
    @(posedge clk);
    for (int n = 0; n < 100 && eng_start == 0; n++) @(negedge clk);
    chk(eng_cx == XM && eng_cy == YM, "R7 restart at pixel 0", eng_cx, XM);
    $display("scenario %s done", tag);
  endtask

  task automatic t_overlap();
    overlap = 0;
    t_frame(3, "overlap");
    chk(overlap > 0, "R4 dispatch and write same cycle", overlap, 1);
  endtask

  task automatic t_saturate();
    saturated = 0;
    t_frame(60, "saturate");
    chk(saturated > 0, "R8 all engines held", saturated, 1);
  endtask

  initial begin
    foreach (hits[k]) hits[k] = 0;
    foreach (cnt[i]) begin cnt[i] = 0; pix_of[i] = 0; cap_x[i] = 0; cap_y[i] = 0; end
    t_reset();
    t_frame(1, "fast");
    t_overlap();
    t_saturate();
    t_frame(8, "mixed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule